// File: doc/BRIEF.md
# Display Command Decoder and Address Generator

This block sits behind a host interface front end of a dot-matrix display controller. It takes command bytes and RAM-data strobes. Command bytes are decoded into the display's configuration registers: panel enable, display start line, contrast level, charge-pump voltage code, charge-pump enable, common scan direction and column mirroring. Most commands are a single byte. Contrast is the exception: an arming byte is followed by a free-form value byte.

Each RAM-data strobe produces one registered write request to the display RAM. The request carries the current page and the segment index. The segment index is the column counter, mirrored when column remapping is on. The column counter then advances by one, but it never goes past the last column and never moves to another page. The host sets the column as two separate nibble commands and sets the page with its own command. An asynchronous active-low reset, released synchronously inside the block, loads fixed defaults.

Top module: `dispctl_top`

## Requirements
- R1: While reset is asserted, and from then on until a command changes them, the outputs hold these defaults: display off, scan normal, pump enabled, pump code 2, start line 0, contrast 80h, no RAM write. Page and column are 0 and mirroring is off. The first strobe after reset therefore writes page 0, segment 0. Reset release takes effect after two clock edges.
- R2: Command byte 0000_nnnn replaces the low nibble of the column counter with nnnn, and 0001_nnnn replaces the high nibble. The other nibble is kept.
- R3: A data strobe makes ram_we high for one cycle after the sampling edge, with ram_page equal to the current page and ram_seg equal to the mapped column. The column then increases by 1 while it is below 131 and stays at 131 once there, so repeated strobes at 131 all write segment 131.
- R4: Command byte 1011_0ppp sets the 3-bit page to ppp. Data strobes never change the page.
- R5: Byte 81h arms the contrast load. The next command byte, whatever its value (81h and AEh included), becomes the contrast value, and the load is disarmed. That byte is not decoded as a command.
- R6: With column mirroring on (A1h), ram_seg is 131 minus the column. With it off (A0h), ram_seg equals the column.
- R7: Command byte 0011_00vv sets the 2-bit pump voltage code to vv.
- R8: Command byte 01ss_ssss sets the 6-bit start line to ssssss.
- R9: AFh turns the display on and AEh turns it off. 8Bh enables the pump and 8Ah disables it. C8h reverses the scan direction and C0h restores it.
- R10: Command bytes outside the defined set (for example 34h, FFh, B8h) change no register.
- R11: A data strobe while the column is above 131 (reachable through the nibble commands) produces no write and leaves the column unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe qualifying cmd_byte |
| cmd_byte | input | 8 | Command or operand byte |
| data_valid | input | 1 | One-cycle RAM-data strobe |
| disp_on | output | 1 | Panel enable |
| scan_rev | output | 1 | Common scan direction reversed |
| pump_en | output | 1 | Internal charge pump enable |
| pump_code | output | 2 | Pump voltage select |
| start_line | output | 6 | Display start line |
| contrast | output | 8 | Contrast level |
| ram_we | output | 1 | RAM write request |
| ram_page | output | 3 | RAM page of the write |
| ram_seg | output | 8 | Segment index of the write, after mirroring |

## Verification
The properties assume that cmd_valid and data_valid are never high in the same cycle. They also assume that each strobe is a single-cycle pulse sampled on a clock edge. The stimulus respects both assumptions: every strobe is raised at a falling edge and dropped at the next falling edge, and only one strobe kind is raised at a time. No strobe is issued while the synchronized reset is still held.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_COL_LO,
    OP_COL_HI,
    OP_PUMP_V,
    OP_START,
    OP_CT_ARM,
    OP_CT_VAL,
    OP_PUMP_OFF,
    OP_PUMP_ON,
    OP_MIRROR_OFF,
    OP_MIRROR_ON,
    OP_DISP_OFF,
    OP_DISP_ON,
    OP_PAGE,
    OP_SCAN_NORM,
    OP_SCAN_REV
  } op_e;

  // Classify one command byte; an armed contrast load captures any byte.
  function automatic op_e classify(input logic [7:0] b, input logic armed);
    op_e k;
    if (armed) begin
      k = OP_CT_VAL;
    end else begin
      casez (b)
        8'b0000_????: k = OP_COL_LO;
        8'b0001_????: k = OP_COL_HI;
        8'b0011_00??: k = OP_PUMP_V;
        8'b01??_????: k = OP_START;
        8'h81:        k = OP_CT_ARM;
        8'h8A:        k = OP_PUMP_OFF;
        8'h8B:        k = OP_PUMP_ON;
        8'hA0:        k = OP_MIRROR_OFF;
        8'hA1:        k = OP_MIRROR_ON;
        8'hAE:        k = OP_DISP_OFF;
        8'hAF:        k = OP_DISP_ON;
        8'b1011_0???: k = OP_PAGE;
        8'hC0:        k = OP_SCAN_NORM;
        8'hC8:        k = OP_SCAN_REV;
        default:      k = OP_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/dispctl_rst_sync.sv
module dispctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dispctl_cmd_dec.sv
module dispctl_cmd_dec
  import dispctl_pkg::*;
#(
  parameter int          LINE_W   = 6,
  parameter int          CT_W     = 8,
  parameter int          PUMP_W   = 2,
  parameter logic [7:0]  CT_RST   = 8'h80,
  parameter int          PUMP_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  output op_e               op,
  output logic              armed,
  output logic              disp_on,
  output logic              scan_rev,
  output logic              mirror,
  output logic              pump_en,
  output logic [PUMP_W-1:0] pump_code,
  output logic [LINE_W-1:0] start_line,
  output logic [CT_W-1:0]   contrast
);
  localparam logic [PUMP_W-1:0] PUMP_DEF = PUMP_W'(PUMP_RST);
  localparam logic [CT_W-1:0]   CT_DEF   = CT_W'(CT_RST);

  logic              armed_q, armed_d;
  logic              disp_q, disp_d;
  logic              scan_q, scan_d;
  logic              mirror_q, mirror_d;
  logic              pen_q, pen_d;
  logic [PUMP_W-1:0] pcode_q, pcode_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [CT_W-1:0]   ct_q, ct_d;

  always_comb begin
    op = cmd_valid ? classify(cmd_byte, armed_q) : OP_NONE;
  end

  always_comb begin
    armed_d  = armed_q;
    disp_d   = disp_q;
    scan_d   = scan_q;
    mirror_d = mirror_q;
    pen_d    = pen_q;
    pcode_d  = pcode_q;
    line_d   = line_q;
    ct_d     = ct_q;
    case (op)
      OP_CT_ARM:     armed_d  = 1'b1;
      OP_CT_VAL: begin
        armed_d = 1'b0;
        ct_d    = cmd_byte[CT_W-1:0];
      end
      OP_PUMP_V:     pcode_d  = cmd_byte[PUMP_W-1:0];
      OP_START:      line_d   = cmd_byte[LINE_W-1:0];
      OP_PUMP_OFF:   pen_d    = 1'b0;
      OP_PUMP_ON:    pen_d    = 1'b1;
      OP_MIRROR_OFF: mirror_d = 1'b0;
      OP_MIRROR_ON:  mirror_d = 1'b1;
      OP_DISP_OFF:   disp_d   = 1'b0;
      OP_DISP_ON:    disp_d   = 1'b1;
      OP_SCAN_NORM:  scan_d   = 1'b0;
      OP_SCAN_REV:   scan_d   = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      disp_q   <= 1'b0;
      scan_q   <= 1'b0;
      mirror_q <= 1'b0;
      pen_q    <= 1'b1;
      pcode_q  <= PUMP_DEF;
      line_q   <= '0;
      ct_q     <= CT_DEF;
    end else if (cmd_valid) begin
      armed_q  <= armed_d;
      disp_q   <= disp_d;
      scan_q   <= scan_d;
      mirror_q <= mirror_d;
      pen_q    <= pen_d;
      pcode_q  <= pcode_d;
      line_q   <= line_d;
      ct_q     <= ct_d;
    end
  end

  assign armed      = armed_q;
  assign disp_on    = disp_q;
  assign scan_rev   = scan_q;
  assign mirror     = mirror_q;
  assign pump_en    = pen_q;
  assign pump_code  = pcode_q;
  assign start_line = line_q;
  assign contrast   = ct_q;
endmodule

// File: rtl/dispctl_addr_gen.sv
module dispctl_addr_gen
  import dispctl_pkg::*;
#(
  parameter int COL_LAST   = 131,
  parameter int PAGE_W     = 3,
  parameter bit HAS_MIRROR = 1'b1,
  localparam int COL_W     = $clog2(COL_LAST + 1),
  localparam int NIB       = COL_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [7:0]        cmd_byte,
  input  logic              data_valid,
  input  logic              mirror,
  output logic [COL_W-1:0]  col,
  output logic [PAGE_W-1:0] page,
  output logic              ram_we,
  output logic [PAGE_W-1:0] ram_page,
  output logic [COL_W-1:0]  ram_seg
);
  localparam logic [COL_W-1:0] LAST_C = COL_W'(COL_LAST);

  logic [COL_W-1:0]  col_q, col_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              we_q, we_d;
  logic [PAGE_W-1:0] wpage_q, wpage_d;
  logic [COL_W-1:0]  wseg_q, wseg_d;
  logic [COL_W-1:0]  seg_map;
  logic              in_range;
  logic              upd_en;

  generate
    if (HAS_MIRROR) begin : g_mirror
      assign seg_map = mirror ? (LAST_C - col_q) : col_q;
    end else begin : g_plain
      assign seg_map = col_q;
    end
  endgenerate

  assign in_range = (col_q <= LAST_C);
  assign upd_en   = data_valid || (op != OP_NONE) || we_q;

  always_comb begin
    col_d   = col_q;
    page_d  = page_q;
    we_d    = 1'b0;
    wpage_d = wpage_q;
    wseg_d  = wseg_q;
    case (op)
      OP_COL_LO: col_d  = {col_q[COL_W-1:NIB], cmd_byte[NIB-1:0]};
      OP_COL_HI: col_d  = {cmd_byte[COL_W-NIB-1:0], col_q[NIB-1:0]};
      OP_PAGE:   page_d = cmd_byte[PAGE_W-1:0];
      default: ;
    endcase
    if (data_valid && in_range) begin
      we_d    = 1'b1;
      wpage_d = page_q;
      wseg_d  = seg_map;
      if (col_q < LAST_C) col_d = col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      page_q  <= '0;
      we_q    <= 1'b0;
      wpage_q <= '0;
      wseg_q  <= '0;
    end else if (upd_en) begin
      col_q   <= col_d;
      page_q  <= page_d;
      we_q    <= we_d;
      wpage_q <= wpage_d;
      wseg_q  <= wseg_d;
    end
  end

  assign col      = col_q;
  assign page     = page_q;
  assign ram_we   = we_q;
  assign ram_page = wpage_q;
  assign ram_seg  = wseg_q;
endmodule

// File: rtl/dispctl_top.sv
module dispctl_top
  import dispctl_pkg::*;
#(
  parameter int COL_LAST = 131,
  parameter int PAGE_W   = 3,
  parameter int LINE_W   = 6,
  parameter int CT_W     = 8,
  parameter int PUMP_W   = 2,
  localparam int COL_W   = $clog2(COL_LAST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  input  logic              data_valid,
  output logic              disp_on,
  output logic              scan_rev,
  output logic              pump_en,
  output logic [PUMP_W-1:0] pump_code,
  output logic [LINE_W-1:0] start_line,
  output logic [CT_W-1:0]   contrast,
  output logic              ram_we,
  output logic [PAGE_W-1:0] ram_page,
  output logic [COL_W-1:0]  ram_seg
);
  logic              rst_sync_n;
  op_e               op;
  logic              armed;
  logic              mirror;
  logic [COL_W-1:0]  col_cur;
  logic [PAGE_W-1:0] page_cur;

  dispctl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dispctl_cmd_dec #(
    .LINE_W (LINE_W),
    .CT_W   (CT_W),
    .PUMP_W (PUMP_W)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .op         (op),
    .armed      (armed),
    .disp_on    (disp_on),
    .scan_rev   (scan_rev),
    .mirror     (mirror),
    .pump_en    (pump_en),
    .pump_code  (pump_code),
    .start_line (start_line),
    .contrast   (contrast)
  );

  dispctl_addr_gen #(
    .COL_LAST (COL_LAST),
    .PAGE_W   (PAGE_W)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .op         (op),
    .cmd_byte   (cmd_byte),
    .data_valid (data_valid),
    .mirror     (mirror),
    .col        (col_cur),
    .page       (page_cur),
    .ram_we     (ram_we),
    .ram_page   (ram_page),
    .ram_seg    (ram_seg)
  );
endmodule

// File: rtl/dispctl_chk.sv
module dispctl_chk #(
  parameter int COL_LAST = 131
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       data_valid,
  input logic       armed,
  input logic [7:0] col_cur,
  input logic [2:0] page_cur,
  input logic       disp_on,
  input logic [5:0] start_line,
  input logic [1:0] pump_code,
  input logic [7:0] contrast,
  input logic       ram_we,
  input logic [7:0] ram_seg
);
  localparam logic [7:0] LAST_C = 8'(COL_LAST);

  p_we_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(data_valid));

  p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !cmd_valid && col_cur < LAST_C) |=> (col_cur == $past(col_cur) + 8'd1));

  p_col_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !cmd_valid && col_cur == LAST_C) |=> (col_cur == LAST_C));

  p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !cmd_valid) |=> $stable(page_cur));

  p_armed_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cmd_valid) |=> (!armed && $stable(disp_on) && $stable(start_line)
                              && $stable(pump_code)));

  p_seg_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_seg <= LAST_C));

  p_idle_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(contrast) && $stable(disp_on) && $stable(start_line)));

  p_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !cmd_valid && col_cur > LAST_C) |=> (!ram_we && $stable(col_cur)));
endmodule

bind dispctl_top dispctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cmd_valid  (cmd_valid),
  .data_valid (data_valid),
  .armed      (armed),
  .col_cur    (col_cur),
  .page_cur   (page_cur),
  .disp_on    (disp_on),
  .start_line (start_line),
  .pump_code  (pump_code),
  .contrast   (contrast),
  .ram_we     (ram_we),
  .ram_seg    (ram_seg)
);

// File: tb/dispctl_top_tb.sv
module dispctl_top_tb;
  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic       data_valid;
  logic       disp_on, scan_rev, pump_en, ram_we;
  logic [1:0] pump_code;
  logic [5:0] start_line;
  logic [7:0] contrast, ram_seg;
  logic [2:0] ram_page;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  dispctl_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .data_valid (data_valid),
    .disp_on    (disp_on),
    .scan_rev   (scan_rev),
    .pump_en    (pump_en),
    .pump_code  (pump_code),
    .start_line (start_line),
    .contrast   (contrast),
    .ram_we     (ram_we),
    .ram_page   (ram_page),
    .ram_seg    (ram_seg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Entry: [38] data strobe, [37:30] byte, [29:11] cfg {disp,scan,pump_en,code,line,contrast},
  // [10:8] page, [7:0] segment (both checked only for data entries)
  localparam int NV = 30;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 8'hAF, 1'b1,1'b0,1'b1,2'd2,6'd0, 8'h80, 3'd0,8'd0},   // R9 display on
    {1'b0, 8'h45, 1'b1,1'b0,1'b1,2'd2,6'd5, 8'h80, 3'd0,8'd0},   // R8
    {1'b0, 8'h31, 1'b1,1'b0,1'b1,2'd1,6'd5, 8'h80, 3'd0,8'd0},   // R7
    {1'b0, 8'h81, 1'b1,1'b0,1'b1,2'd1,6'd5, 8'h80, 3'd0,8'd0},   // R5 arm
    {1'b0, 8'hAE, 1'b1,1'b0,1'b1,2'd1,6'd5, 8'hAE, 3'd0,8'd0},   // R5 operand, not display off
    {1'b0, 8'h81, 1'b1,1'b0,1'b1,2'd1,6'd5, 8'hAE, 3'd0,8'd0},   // R5 arm
    {1'b0, 8'h00, 1'b1,1'b0,1'b1,2'd1,6'd5, 8'h00, 3'd0,8'd0},   // R5 operand, not column
    {1'b0, 8'h8A, 1'b1,1'b0,1'b0,2'd1,6'd5, 8'h00, 3'd0,8'd0},   // R9 pump off
    {1'b0, 8'hC8, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd0,8'd0},   // R9 scan reverse
    {1'b0, 8'h34, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd0,8'd0},   // R10
    {1'b0, 8'hFF, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd0,8'd0},   // R10
    {1'b0, 8'hB3, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd0,8'd0},   // R4
    {1'b0, 8'hB8, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd0,8'd0},   // R10 page kept at 3
    {1'b0, 8'h02, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd0,8'd0},   // R2 low nibble
    {1'b0, 8'h11, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd0,8'd0},   // R2 high nibble
    {1'b1, 8'h00, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd3,8'd18},  // R3 R4
    {1'b1, 8'h00, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd3,8'd19},  // R3
    {1'b0, 8'hA1, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd0,8'd0},   // R6 mirror on
    {1'b1, 8'h00, 1'b1,1'b1,1'b0,2'd1,6'd5, 8'h00, 3'd3,8'd111}, // R6 131-20
    {1'b0, 8'h7F, 1'b1,1'b1,1'b0,2'd1,6'd63,8'h00, 3'd0,8'd0},   // R8
    {1'b0, 8'h33, 1'b1,1'b1,1'b0,2'd3,6'd63,8'h00, 3'd0,8'd0},   // R7
    {1'b0, 8'h8B, 1'b1,1'b1,1'b1,2'd3,6'd63,8'h00, 3'd0,8'd0},   // R9 pump on
    {1'b0, 8'hA0, 1'b1,1'b1,1'b1,2'd3,6'd63,8'h00, 3'd0,8'd0},   // R6 mirror off
    {1'b0, 8'h03, 1'b1,1'b1,1'b1,2'd3,6'd63,8'h00, 3'd0,8'd0},   // R2
    {1'b0, 8'h18, 1'b1,1'b1,1'b1,2'd3,6'd63,8'h00, 3'd0,8'd0},   // R2 column 131
    {1'b1, 8'h00, 1'b1,1'b1,1'b1,2'd3,6'd63,8'h00, 3'd3,8'd131}, // R3 last column
    {1'b1, 8'h00, 1'b1,1'b1,1'b1,2'd3,6'd63,8'h00, 3'd3,8'd131}, // R3 saturated
    {1'b0, 8'hA1, 1'b1,1'b1,1'b1,2'd3,6'd63,8'h00, 3'd0,8'd0},   // R6
    {1'b1, 8'h00, 1'b1,1'b1,1'b1,2'd3,6'd63,8'h00, 3'd3,8'd0},   // R6 131-131
    {1'b0, 8'hC0, 1'b1,1'b0,1'b1,2'd3,6'd63,8'h00, 3'd0,8'd0}    // R9 scan normal
  };

  function automatic logic [18:0] cfg_now();
    return {disp_on, scan_rev, pump_en, pump_code, start_line, contrast};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic is_data, input logic [7:0] b);
    @(negedge clk);
    cmd_valid  = !is_data;
    data_valid = is_data;
    cmd_byte   = b;
    @(negedge clk);
    cmd_valid  = 1'b0;
    data_valid = 1'b0;
    cmd_byte   = 8'h00;
  endtask

  task automatic check_defaults(input string tag);
    check({tag, " cfg"}, 32'(cfg_now()), 32'({1'b0,1'b0,1'b1,2'd2,6'd0,8'h80}));
    check({tag, " we"},  32'(ram_we), 32'd0);
  endtask

  initial begin
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    data_valid = 1'b0;
    cmd_byte   = 8'h00;
    repeat (3) @(negedge clk);
    check_defaults("R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_defaults("R1 after release");

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      send(v[38], v[37:30]);
      check($sformatf("vector %0d cfg", i), 32'(cfg_now()), 32'(v[29:11]));
      check($sformatf("vector %0d we", i), 32'(ram_we), 32'(v[38]));
      if (v[38]) begin
        check($sformatf("vector %0d page", i), 32'(ram_page), 32'(v[10:8]));
        check($sformatf("vector %0d seg", i), 32'(ram_seg), 32'(v[7:0]));
      end
    end

    // R5: a second 81h is taken as the operand, then AEh decodes normally
    send(1'b0, 8'h81);
    send(1'b0, 8'h81);
    check("R5 81h as operand", 32'(contrast), 32'h81);
    check("R5 display kept on", 32'(disp_on), 32'd1);
    send(1'b0, 8'hAE);
    check("R5 disarmed, R9 display off", 32'(disp_on), 32'd0);
    check("R5 contrast kept", 32'(contrast), 32'h81);

    // R11: column 90h is out of range, so strobes do not write
    send(1'b0, 8'h00);
    send(1'b0, 8'h19);
    send(1'b1, 8'h00);
    check("R11 no write", 32'(ram_we), 32'd0);
    send(1'b1, 8'h00);
    check("R11 column unchanged, still no write", 32'(ram_we), 32'd0);
    send(1'b0, 8'h10);   // column 00h, low nibble kept (R2)
    send(1'b1, 8'h00);   // mirror still on
    check("R2 R11 low nibble kept, we", 32'(ram_we), 32'd1);
    check("R2 R11 low nibble kept, seg", 32'(ram_seg), 32'd131);

    // R1: reset in the middle of operation, with a contrast load armed
    send(1'b0, 8'h81);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_defaults("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send(1'b0, 8'hAF);
    check("R1 disarmed by reset", 32'(disp_on), 32'd1);
    check("R1 contrast default", 32'(contrast), 32'h80);
    send(1'b1, 8'h00);
    check("R1 page reset", 32'(ram_page), 32'd0);
    check("R1 column and mirror reset", 32'(ram_seg), 32'd0);
    check("R3 one-cycle write pulse", 32'(ram_we), 32'd1);
    @(negedge clk);
    check("R3 write pulse ends", 32'(ram_we), 32'd0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule